// File: doc/BRIEF.md
# Debug Bus-Grant Control Register

This block sits in the debug register space and decides when an external peripheral may take the processor's address and data buses. A byte-wide control register holds two live bits: a request-enable bit and a manual-acknowledge bit. An external bus request arrives asynchronously. It is brought into the clock domain through a synchroniser and then gated by the request-enable bit. A grant is never given while the debug engine reports an operation in progress. It is given on the first cycle after that operation ends.

Software can also drive the acknowledge directly. Setting the manual bit hands the buses out at once. Clearing it takes them back, unless a request-driven grant is still holding them. The registered acknowledge is copied onto a bus-release output, which tells the processor-side drivers to tri-state. All pins are plain control and status lines, so the block has no valid/ready stream and no back-pressure.

Top module: `bus_grant_ctl`

## Requirements
- R1: While the request-enable bit (bit 7) is 0, an asserted bus request never causes the acknowledge output to rise.
- R2: With bit 7 at 1, debug idle and bit 6 at 0, a request asserted before clock edge k is passed through two synchroniser flops. The acknowledge then goes high after edge k+2.
- R3: While the debug-busy input is high, a new request-driven grant is held back. It is issued by the first clock edge at which busy is sampled low.
- R4: Writing 1 to bit 6 drives the acknowledge high after the clock edge that follows the register write.
- R5: Writing 0 to bit 6, with no request-driven grant active, drives the acknowledge low after the clock edge that follows the register write.
- R6: Reads return bit 7 and bit 6 as last written. Bits 5:0 always read 0, and writes to them have no effect.
- R7: A request-driven grant stays asserted while the request is held. When the request is withdrawn before edge k, the acknowledge drops after edge k+2.
- R8: Reset (active-low, asynchronous) clears both control bits and the acknowledge.
- R9: The bus-release output always equals the acknowledge output.
- R10: Once a request-driven grant is active, busy rising again does not remove it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Write strobe for the control register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Register read value |
| ext_req_i | input | 1 | Asynchronous external bus request |
| dbg_busy_i | input | 1 | Debug operation in progress |
| bus_ack_o | output | 1 | Registered bus acknowledge |
| bus_release_o | output | 1 | Tri-state command to processor-side bus drivers |

## Verification
Read data follows a write after one edge. A manual-bit change reaches the acknowledge one edge later still. A change on the request pin reaches the acknowledge three edges after it was driven: two synchroniser flops plus the output register. A busy release is seen by the acknowledge on the next edge. The bench drives inputs and samples outputs on falling edges, and it waits exactly those edge counts before each directed comparison. In the random phase, a cycle model built from the requirements advances on each rising edge, and it is compared with the outputs on the following falling edge.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
  localparam int REG_W   = 8;
  localparam int EN_BIT  = 7;
  localparam int MAN_BIT = 6;

  typedef struct packed {
    logic req_en;
    logic man_ack;
  } bgc_ctrl_t;
endpackage

// File: rtl/bgc_sync.sv
module bgc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= 1'b0;
        else if (g == 0) pipe[g] <= d_i;
        else pipe[g] <= pipe[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/bgc_ctrl_reg.sv
module bgc_ctrl_reg
  import bgc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output bgc_ctrl_t        ctrl_o
);
  bgc_ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_i) begin
      ctrl_q.req_en  <= wdata_i[EN_BIT];
      ctrl_q.man_ack <= wdata_i[MAN_BIT];
    end
  end

  always_comb begin
    rdata_o          = '0;
    rdata_o[EN_BIT]  = ctrl_q.req_en;
    rdata_o[MAN_BIT] = ctrl_q.man_ack;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/bgc_grant.sv
module bgc_grant
  import bgc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bgc_ctrl_t ctrl_i,
  input  logic      req_i,
  input  logic      busy_i,
  output logic      ack_o
);
  logic grant_q, grant_d, ack_q;

  // A grant starts only when debug is idle; once held it survives busy.
  assign grant_d = ctrl_i.req_en & req_i & (grant_q | ~busy_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      grant_q <= grant_d;
      ack_q   <= ctrl_i.man_ack | grant_d;
    end
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/bus_grant_ctl.sv
module bus_grant_ctl
  import bgc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             ext_req_i,
  input  logic             dbg_busy_i,
  output logic             bus_ack_o,
  output logic             bus_release_o
);
  bgc_ctrl_t ctrl;
  logic      req_s;
  logic      ack;

  bgc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ext_req_i), .q_o(req_s)
  );

  bgc_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .ctrl_o(ctrl)
  );

  bgc_grant u_grant (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .req_i(req_s),
    .busy_i(dbg_busy_i), .ack_o(ack)
  );

  assign bus_ack_o     = ack;
  assign bus_release_o = ack;
endmodule

// File: rtl/bus_grant_ctl_chk.sv
module bus_grant_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_rdata,
  input logic       dbg_busy,
  input logic       bus_ack,
  input logic       bus_release,
  input logic       req_sync
);
  a_r1_no_ack_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[7] && !reg_rdata[6]) |=> !bus_ack);

  a_r4_manual_ack: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6] |=> bus_ack);

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[5:0] == 6'b0);

  a_r9_release_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release == bus_ack);

  a_r7_drop_on_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[6] && !req_sync) |=> !bus_ack);

  a_r3_defer_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_busy && !bus_ack && !reg_rdata[6]) |=> !bus_ack);
endmodule

bind bus_grant_ctl bus_grant_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata_o), .dbg_busy(dbg_busy_i),
  .bus_ack(bus_ack_o), .bus_release(bus_release_o), .req_sync(req_s)
);

// File: tb/tb_bus_grant_ctl.sv
module tb_bus_grant_ctl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ext_req = 1'b0;
  logic       dbg_busy = 1'b0;
  logic       bus_ack, bus_release;

  int checks = 0;
  int failures = 0;

  // requirement-level cycle model
  logic m_en, m_man, m_s1, m_s2, m_grant, m_ack;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_grant_ctl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .ext_req_i(ext_req), .dbg_busy_i(dbg_busy),
    .bus_ack_o(bus_ack), .bus_release_o(bus_release)
  );

  function automatic logic next_grant(logic en, logic req, logic held, logic busy);
    return en & req & (held | ~busy);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_man <= 0; m_s1 <= 0; m_s2 <= 0; m_grant <= 0; m_ack <= 0;
    end else begin
      if (reg_wr) begin m_en <= reg_wdata[7]; m_man <= reg_wdata[6]; end
      m_s1 <= ext_req;
      m_s2 <= m_s1;
      m_grant <= next_grant(m_en, m_s2, m_grant, dbg_busy);
      m_ack <= m_man | next_grant(m_en, m_s2, m_grant, dbg_busy);
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(3);
    chk("R8 ack in reset", {7'b0, bus_ack}, 8'h00);
    chk("R8 regs in reset", reg_rdata, 8'h00);
    rst_n = 1'b1;
    cyc(2);
    chk("R8 ack after reset", {7'b0, bus_ack}, 8'h00);

    // R6 reserved bits
    wr(8'hFF);
    chk("R6 readback", reg_rdata, 8'hC0);
    wr(8'h00);
    chk("R5 clear readback", reg_rdata, 8'h00);
    cyc(1);
    chk("R5 manual clear drops ack", {7'b0, bus_ack}, 8'h00);

    // R1 disabled
    ext_req = 1'b1; cyc(6);
    chk("R1 request ignored", {7'b0, bus_ack}, 8'h00);
    ext_req = 1'b0; cyc(4);

    // R4 manual
    wr(8'h40);
    cyc(1);
    chk("R4 manual ack", {7'b0, bus_ack}, 8'h01);
    chk("R9 release", {7'b0, bus_release}, 8'h01);
    wr(8'h00);
    cyc(1);
    chk("R5 manual release", {7'b0, bus_ack}, 8'h00);

    // R2 latency with idle debug
    wr(8'h80);
    ext_req = 1'b1;
    cyc(2);
    chk("R2 not before sync", {7'b0, bus_ack}, 8'h00);
    cyc(1);
    chk("R2 ack after sync", {7'b0, bus_ack}, 8'h01);
    // R10 busy after grant
    dbg_busy = 1'b1; cyc(3);
    chk("R10 grant held under busy", {7'b0, bus_ack}, 8'h01);
    dbg_busy = 1'b0;
    // R7 withdraw
    ext_req = 1'b0;
    cyc(2);
    chk("R7 still held", {7'b0, bus_ack}, 8'h01);
    cyc(1);
    chk("R7 dropped", {7'b0, bus_ack}, 8'h00);

    // R3 deferral
    dbg_busy = 1'b1; ext_req = 1'b1;
    cyc(8);
    chk("R3 deferred while busy", {7'b0, bus_ack}, 8'h00);
    dbg_busy = 1'b0;
    cyc(1);
    chk("R3 granted after busy ends", {7'b0, bus_ack}, 8'h01);
    ext_req = 1'b0; cyc(4);
    wr(8'h00); cyc(2);

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      reg_wr    = ($urandom_range(0, 19) == 0);
      reg_wdata = 8'($urandom);
      if ($urandom_range(0, 7) == 0) ext_req = ~ext_req;
      if ($urandom_range(0, 3) == 0) dbg_busy = ~dbg_busy;
      @(negedge clk);
      chk("R2 random ack", {7'b0, bus_ack}, {7'b0, m_ack});
      chk("R9 random release", {7'b0, bus_release}, {7'b0, m_ack});
      chk("R6 random readback", reg_rdata, {m_en, m_man, 6'b0});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule